// File: doc/BRIEF.md
# Branch Direction Predictor with Selectable Policy

This block guesses whether a conditional branch will be taken. A two-bit mode input chooses the policy. Two policies are static: always not-taken or always taken. The third is a bimodal table of two-bit saturating counters indexed directly by the branch address. The fourth is a two-level adaptive scheme. Its first table keeps a per-address shift register of recent outcomes, and that history selects a counter in a second table.

A front end raises a lookup with the branch address. The registered prediction appears on the following cycle. When the branch resolves, the back end sends an update carrying the same address and the real outcome. Updates train the bimodal table and both two-level tables whatever the current mode, so a mode switch finds warm state. The sizes of the bimodal table, the history table and the pattern table are independent parameters, and so is the history width.

Top module: `bp_direction_predictor`

## Requirements
- R1: After reset the prediction valid and taken outputs are 0. Every counter starts at 1 (weakly not-taken) and every history register starts at 0, so the first lookups in bimodal and two-level modes predict not-taken.
- R2: Mode 0 always predicts not-taken and mode 1 always predicts taken, whatever training has happened.
- R3: A lookup accepted at a clock edge produces `pred_valid_o` high, with its prediction, for exactly the next cycle. When no lookup is made, both outputs are 0 in that cycle.
- R4: In mode 2 (bimodal), the counter is selected by address bits starting at bit ALIGN_BITS. It is log2(BIM_ENTRIES) bits wide.
- R5: A counter predicts taken when its value is 2 or 3. It increments on a taken update and decrements on a not-taken update, and it saturates at 3 and at 0.
- R6: In mode 3 (two-level), a history register is selected by address bits starting at bit ALIGN_BITS, log2(L1_ENTRIES) bits wide. On an update the outcome shifts in at bit 0 and the oldest bit is dropped.
- R7: In mode 3, the pattern counter index is the history value, truncated or zero-extended to log2(L2_ENTRIES) bits. The prediction is that counter's upper bit.
- R8: Updates train the bimodal table, the history table and the pattern table in every mode.
- R9: A lookup in the same cycle as an update sees the tables as they were before that update. Address bits below ALIGN_BITS, and bits above a table's index field, do not affect which entry a lookup or update selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy: 0 not-taken, 1 taken, 2 bimodal, 3 two-level |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | ADDR_W | Branch address for the lookup |
| pred_valid_o | output | 1 | Prediction present (one cycle after lookup) |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| up_valid_i | input | 1 | Update request |
| up_addr_i | input | ADDR_W | Address of the resolved branch |
| up_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The properties assume that `mode_i`, `lk_valid_i` and `rst_n` carry known values at every rising edge. They also assume that reset is released away from a clock edge, so the first registered cycle has a defined lookup input. The bench drives every input only at the falling edge and holds it through the following rising edge. It releases reset at a falling edge with all requests low, and it samples results at the next falling edge. The bench never leaves a request undefined, and it moves the mode only between cycles, so the properties always judge a stable request against the output it produced.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        MODE_NOT_TAKEN = 2'd0,
        MODE_TAKEN     = 2'd1,
        MODE_BIMODAL   = 2'd2,
        MODE_TWO_LEVEL = 2'd3
    } bp_mode_e;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_RESET = 2'd1;
    localparam ctr2_t CTR_MAX   = 2'd3;
    localparam ctr2_t CTR_MIN   = 2'd0;

    // saturating step of a two-bit confidence counter
    function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
        ctr2_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_MAX) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr2_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    typedef struct {
        ctr2_t ctr [ENTRIES];
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = ctr_step(st_q.ctr[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.ctr[i] <= CTR_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ctr = st_q.ctr[rd_idx];

endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
    parameter int ENTRIES = 8,
    parameter int HIST_W  = 4,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [HIST_W-1:0] rd_a_hist,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [HIST_W-1:0] rd_b_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken
);

    typedef logic [HIST_W-1:0] hist_t;

    typedef struct {
        hist_t hist [ENTRIES];
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            // newest outcome enters at bit 0, oldest falls off the top
            st_d.hist[wr_idx] = HIST_W'({st_q.hist[wr_idx], wr_taken});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.hist[i] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_hist = st_q.hist[rd_a_idx];
    assign rd_b_hist = st_q.hist[rd_b_idx];

endmodule

// File: rtl/bp_direction_predictor.sv
module bp_direction_predictor
    import bp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ALIGN_BITS  = 2,
    parameter int BIM_ENTRIES = 16,
    parameter int L1_ENTRIES  = 8,
    parameter int HIST_W      = 4,
    parameter int L2_ENTRIES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              pred_valid_o,
    output logic              pred_taken_o,
    input  logic              up_valid_i,
    input  logic [ADDR_W-1:0] up_addr_i,
    input  logic              up_taken_i
);

    localparam int BIM_IDX_W = $clog2(BIM_ENTRIES);
    localparam int L1_IDX_W  = $clog2(L1_ENTRIES);
    localparam int L2_IDX_W  = $clog2(L2_ENTRIES);

    typedef struct packed {
        logic valid;
        logic taken;
    } out_state_t;

    logic [ADDR_W-1:0]    lk_word, up_word;
    logic [BIM_IDX_W-1:0] bim_lk_idx, bim_up_idx;
    logic [L1_IDX_W-1:0]  l1_lk_idx, l1_up_idx;
    logic [L2_IDX_W-1:0]  l2_lk_idx, l2_up_idx;
    logic [HIST_W-1:0]    lk_hist, up_hist;
    ctr2_t                bim_lk_ctr, l2_lk_ctr;
    out_state_t           st_d, st_q;
    bp_mode_e             mode;
    logic                 unused_bits;

    // strip the alignment bits, then keep only what each table indexes
    assign lk_word    = lk_addr_i >> ALIGN_BITS;
    assign up_word    = up_addr_i >> ALIGN_BITS;
    assign bim_lk_idx = BIM_IDX_W'(lk_word);
    assign bim_up_idx = BIM_IDX_W'(up_word);
    assign l1_lk_idx  = L1_IDX_W'(lk_word);
    assign l1_up_idx  = L1_IDX_W'(up_word);
    assign l2_lk_idx  = L2_IDX_W'(lk_hist);
    assign l2_up_idx  = L2_IDX_W'(up_hist);
    assign mode       = bp_mode_e'(mode_i);

    assign unused_bits = ^{lk_word, up_word, lk_hist, up_hist,
                           bim_lk_ctr[0], l2_lk_ctr[0]};

    bp_ctr_table #(
        .ENTRIES (BIM_ENTRIES)
    ) u_bim (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (bim_lk_idx),
        .rd_ctr   (bim_lk_ctr),
        .wr_en    (up_valid_i),
        .wr_idx   (bim_up_idx),
        .wr_taken (up_taken_i)
    );

    bp_hist_table #(
        .ENTRIES (L1_ENTRIES),
        .HIST_W  (HIST_W)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (l1_lk_idx),
        .rd_a_hist (lk_hist),
        .rd_b_idx  (l1_up_idx),
        .rd_b_hist (up_hist),
        .wr_en     (up_valid_i),
        .wr_idx    (l1_up_idx),
        .wr_taken  (up_taken_i)
    );

    bp_ctr_table #(
        .ENTRIES (L2_ENTRIES)
    ) u_pattern (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (l2_lk_idx),
        .rd_ctr   (l2_lk_ctr),
        .wr_en    (up_valid_i),
        .wr_idx   (l2_up_idx),
        .wr_taken (up_taken_i)
    );

    always_comb begin
        st_d.valid = lk_valid_i;
        st_d.taken = 1'b0;
        if (lk_valid_i) begin
            unique case (mode)
                MODE_NOT_TAKEN: st_d.taken = 1'b0;
                MODE_TAKEN:     st_d.taken = 1'b1;
                MODE_BIMODAL:   st_d.taken = ctr_says_taken(bim_lk_ctr);
                MODE_TWO_LEVEL: st_d.taken = ctr_says_taken(l2_lk_ctr);
                default:        st_d.taken = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_valid_o = st_q.valid;
    assign pred_taken_o = st_q.taken;

endmodule

// File: rtl/bp_direction_predictor_chk.sv
module bp_direction_predictor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       lk_valid_i,
    input logic       pred_valid_o,
    input logic       pred_taken_o
);

    // R3
    lookup_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> pred_valid_o);

    // R3
    idle_gives_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> (!pred_valid_o && !pred_taken_o));

    // R2
    static_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && mode_i == 2'd0) |=> !pred_taken_o);

    // R2
    static_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && mode_i == 2'd1) |=> pred_taken_o);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!pred_valid_o && !pred_taken_o);
        end
    end

endmodule

bind bp_direction_predictor bp_direction_predictor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .lk_valid_i   (lk_valid_i),
    .pred_valid_o (pred_valid_o),
    .pred_taken_o (pred_taken_o)
);

// File: tb/bp_direction_predictor_test.sv
`timescale 1ns/1ps
module bp_direction_predictor_test;

    localparam int AW   = 12;
    localparam int ALN  = 2;
    localparam int NBIM = 8;
    localparam int NL1  = 4;
    localparam int HW   = 3;
    localparam int NL2  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic          lk_v, up_v, up_t;
    logic [AW-1:0] lk_a, up_a;
    logic          pv, pt;

    int checks = 0;
    int errors = 0;
    int bim_m [NBIM];
    int l1_m  [NL1];
    int l2_m  [NL2];
    logic [15:0] lf = 16'hACE1;

    bp_direction_predictor #(
        .ADDR_W(AW), .ALIGN_BITS(ALN), .BIM_ENTRIES(NBIM),
        .L1_ENTRIES(NL1), .HIST_W(HW), .L2_ENTRIES(NL2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .lk_valid_i(lk_v), .lk_addr_i(lk_a),
        .pred_valid_o(pv), .pred_taken_o(pt),
        .up_valid_i(up_v), .up_addr_i(up_a), .up_taken_i(up_t)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int c, input bit t);
        if (t) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    // one request cycle; called at a falling edge, returns at the next one
    task automatic step(input string req, input int m, input bit lv, input int la,
                        input bit uv, input int ua, input bit ut);
        int exp, h;
        mode = 2'(m); lk_v = lv; lk_a = AW'(la);
        up_v = uv; up_a = AW'(ua); up_t = ut;
        case (m)
            0: exp = 0;
            1: exp = 1;
            2: exp = (bim_m[(la >> ALN) % NBIM] >= 2) ? 1 : 0;
            default: exp = (l2_m[l1_m[(la >> ALN) % NL1] % NL2] >= 2) ? 1 : 0;
        endcase
        @(posedge clk);
        if (uv) begin
            bim_m[(ua >> ALN) % NBIM] = sat(bim_m[(ua >> ALN) % NBIM], ut);
            h = l1_m[(ua >> ALN) % NL1];
            l2_m[h % NL2] = sat(l2_m[h % NL2], ut);
            l1_m[(ua >> ALN) % NL1] = ((h << 1) | int'(ut)) % (1 << HW);
        end
        @(negedge clk);
        chk({req, " valid"}, int'(pv), int'(lv));
        chk({req, " taken"}, int'(pt), lv ? exp : 0);
        lk_v = 1'b0; up_v = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBIM; i++) bim_m[i] = 1;
        for (int i = 0; i < NL1; i++)  l1_m[i] = 0;
        for (int i = 0; i < NL2; i++)  l2_m[i] = 1;
        rst_n = 1'b0; mode = 2'd0; lk_v = 0; up_v = 0; up_t = 0; lk_a = '0; up_a = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(pv), 0);
        chk("R1 reset taken", int'(pt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: fresh tables predict not-taken everywhere
        for (int a = 0; a < 64; a += 4) begin
            step("R1 bim", 2, 1, a, 0, 0, 0);
            step("R1 two", 3, 1, a, 0, 0, 0);
        end
        // R3: idle cycle keeps outputs low
        step("R3 idle", 1, 0, 0, 0, 0, 0);
        // R5: drive one counter to the top, then one step back
        for (int k = 0; k < 5; k++) step("R5 up", 2, 1, 'h40, 1, 'h40, 1);
        step("R5 down", 2, 1, 'h40, 1, 'h40, 0);
        step("R5 still", 2, 1, 'h40, 0, 0, 0);
        for (int k = 0; k < 5; k++) step("R5 floor", 2, 1, 'h44, 1, 'h44, 0);
        // R2: static modes ignore trained state
        step("R2 nt", 0, 1, 'h40, 0, 0, 0);
        step("R2 t", 1, 1, 'h44, 0, 0, 0);
        // R9: low bits and aliasing above the index
        for (int lo = 0; lo < 4; lo++) step("R9 align", 2, 1, 'h40 + lo, 0, 0, 0);
        step("R9 alias", 2, 1, 'h40 + NBIM * 4, 0, 0, 0);
        // R9: same-cycle lookup sees pre-update state
        step("R9 same", 2, 1, 'h48, 1, 'h48, 1);
        step("R9 same", 2, 1, 'h48, 1, 'h48, 1);
        // R8: training in static mode reaches the tables
        for (int k = 0; k < 3; k++) step("R8 train", 0, 0, 0, 1, 'h50, 1);
        step("R8 bim", 2, 1, 'h50, 0, 0, 0);
        step("R8 two", 3, 1, 'h50, 0, 0, 0);
        // R6 R7: alternating pattern learned by the two-level scheme
        for (int k = 0; k < 24; k++) step("R7 alt", 3, 1, 'h20, 1, 'h20, k[0]);
        for (int k = 0; k < 24; k++) step("R6 period3", 3, 1, 'h24, 1, 'h24, (k % 3) != 0);
        // R4 R7: pseudo-random sweep over all modes and a small address window
        for (int k = 0; k < 4000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step((lf[1:0] == 2'd2) ? "R4 sweep" : "R7 sweep", int'(lf[1:0]),
                 lf[2], int'(lf[9:4]), lf[3], int'(lf[15:10]), lf[11] ^ lf[4]);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule